// File: doc/BRIEF.md
# Dispatch Steering Unit

This block sits between register renaming and the back-end queues of an out-of-order core. Each cycle it takes one renamed group of up to `WIDTH` instructions and decides, slot by slot and in ascending slot order, where each one goes. The possible outcomes are:

- A squashed slot is discarded.
- A memory operation reserves a load-side or a store-side entry in the load/store queue and also takes an instruction-queue entry.
- A non-speculative instruction is flagged ready to commit and goes through a dedicated insertion port rather than the normal one.
- A no-op is retired on the spot: it is marked issued, executed and ready to commit, and it only moves the instruction-queue tail.
- Anything else is inserted into the instruction queue as an ordinary operation.

The unit carries a running count of free instruction-queue entries through the group. The count starts from the `iq_free` input and drops by one for every slot that claims an entry. When a slot that has not been squashed finds the count at zero, the rest of the group is abandoned. The unit then raises a block request toward its own control and a stall toward rename. Every routing strobe, the per-cycle counts and the block/stall pair are registered, so they appear one clock after the group is presented.

Top module: `dsu_top`

## Requirements
- R1: Only slots with index below `grp_size` are considered. Slots at or above it, and slots after the point where dispatch stopped, drive no strobe at all.
- R2: A slot whose squash bit is set is dropped (`drop_o`), is counted in `cnt_drop_o` and claims no queue entry. This check is made before the full check, so a squashed slot is dropped even when no entry is free, and processing continues with the next slot.
- R3: The first unsquashed active slot that meets a free count of zero gets no strobe. No later slot is touched. `block_o` and `stall_o` are both raised for that cycle; a `block_o` pulse is the queue-full event.
- R4: Class code 1 (load) raises `ld_o` and `iq_o` for the slot. Class code 2 (store) raises `st_o` and `iq_o`. Loads and stores are counted separately in `cnt_ld_o` and `cnt_st_o`.
- R5: Class code 3 (non-speculative) raises `ns_o`, which also marks the instruction ready to commit, and never raises `iq_o`.
- R6: Class code 4 (no-op) raises `nop_o`, meaning issued, executed and ready to commit, and never raises `iq_o`.
- R7: Class codes 0, 5, 6 and 7 are ordinary instructions and raise `iq_o`. `cnt_disp_o` counts all `iq_o` strobes of the cycle.
- R8: Every slot routed by R4 to R7 lowers the free count by one for the following slots, so the number of such slots never exceeds `iq_free`.
- R9: All outputs are registered with one cycle of latency, and all of them are zero while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_size | input | CNT_W | Number of valid slots in the group, 0 to WIDTH |
| grp_cls | input | 3*WIDTH | Class code per slot, slot k in bits 3k+2:3k |
| grp_sq | input | WIDTH | Squash bit per slot |
| iq_free | input | FREE_W | Free instruction-queue entries at the start of the cycle |
| iq_o | output | WIDTH | Insert into instruction queue, per slot |
| ld_o | output | WIDTH | Reserve load-side entry, per slot |
| st_o | output | WIDTH | Reserve store-side entry, per slot |
| ns_o | output | WIDTH | Non-speculative insertion, commit-ready, per slot |
| nop_o | output | WIDTH | No-op completed, tail advance, per slot |
| drop_o | output | WIDTH | Squashed slot dropped, per slot |
| cnt_drop_o | output | CNT_W | Dropped slots this cycle |
| cnt_ld_o | output | CNT_W | Loads this cycle |
| cnt_st_o | output | CNT_W | Stores this cycle |
| cnt_disp_o | output | CNT_W | Instruction-queue insertions this cycle |
| block_o | output | 1 | Block request / queue-full event |
| stall_o | output | 1 | Stall toward rename |

## Verification
The assertions check these properties on every cycle:

- No slot is both a load and a store, and every memory strobe is paired with a queue insertion.
- A slot takes at most one of the dropped, inserted, non-speculative or no-op paths.
- Touched slots form an unbroken run from slot 0 that is no longer than the presented group.
- A stall always coincides with exactly the previously reported free entries having been consumed.

Only the bench's scenarios can show the following:

- Each class code lands on the right strobe.
- A squashed slot is dropped ahead of a full queue.
- The truncation point moves as the free count changes.
- The counts match the strobes.

It covers these by comparison against an independent per-slot model under random and directed groups.

// File: rtl/dsu_pkg.sv
package dsu_pkg;

  localparam logic [2:0] CLS_LOAD  = 3'd1;
  localparam logic [2:0] CLS_STORE = 3'd2;
  localparam logic [2:0] CLS_NSPEC = 3'd3;
  localparam logic [2:0] CLS_NOP   = 3'd4;

  typedef struct packed {
    logic iq;
    logic ld;
    logic st;
    logic ns;
    logic nop;
    logic drop;
    logic take;   // slot claims one instruction-queue entry
    logic full;   // slot met an empty queue: dispatch stops here
  } route_t;

  // Priority per slot: squashed, queue full, then class routing.
  function automatic route_t steer(input logic act, input logic sq,
                                   input logic [2:0] code, input logic full);
    route_t r;
    r = '0;
    if (act) begin
      if (sq)        r.drop = 1'b1;
      else if (full) r.full = 1'b1;
      else begin
        r.take = 1'b1;
        case (code)
          CLS_LOAD:  begin r.ld = 1'b1; r.iq = 1'b1; end
          CLS_STORE: begin r.st = 1'b1; r.iq = 1'b1; end
          CLS_NSPEC: r.ns  = 1'b1;
          CLS_NOP:   r.nop = 1'b1;
          default:   r.iq  = 1'b1;
        endcase
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/dsu_chain.sv
module dsu_chain
  import dsu_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter int FREE_W = 4,
  localparam int CNT_W = $clog2(WIDTH + 1)
) (
  input  logic [CNT_W-1:0]   grp_size,
  input  logic [3*WIDTH-1:0] grp_cls,
  input  logic [WIDTH-1:0]   grp_sq,
  input  logic [FREE_W-1:0]  iq_free,
  output logic [WIDTH-1:0]   iq_c,
  output logic [WIDTH-1:0]   ld_c,
  output logic [WIDTH-1:0]   st_c,
  output logic [WIDTH-1:0]   ns_c,
  output logic [WIDTH-1:0]   nop_c,
  output logic [WIDTH-1:0]   drop_c,
  output logic               full_c
);
  logic [FREE_W-1:0] avail;
  logic              stopped;
  route_t            rt;

  always_comb begin
    avail   = iq_free;
    stopped = 1'b0;
    iq_c = '0; ld_c = '0; st_c = '0; ns_c = '0; nop_c = '0; drop_c = '0;
    rt = '0;
    for (int i = 0; i < WIDTH; i++) begin
      rt = steer((CNT_W'(i) < grp_size) && !stopped, grp_sq[i],
                 grp_cls[3*i +: 3], avail == '0);
      iq_c[i]   = rt.iq;
      ld_c[i]   = rt.ld;
      st_c[i]   = rt.st;
      ns_c[i]   = rt.ns;
      nop_c[i]  = rt.nop;
      drop_c[i] = rt.drop;
      if (rt.full) stopped = 1'b1;
      if (rt.take) avail = avail - FREE_W'(1);
    end
    full_c = stopped;
  end
endmodule

// File: rtl/dsu_tally.sv
module dsu_tally #(
  parameter int WIDTH = 4,
  localparam int CNT_W = $clog2(WIDTH + 1)
) (
  input  logic [WIDTH-1:0] bits,
  output logic [CNT_W-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < WIDTH; i++) cnt = cnt + CNT_W'(bits[i]);
  end
endmodule

// File: rtl/dsu_top.sv
module dsu_top
  import dsu_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter int FREE_W = 4,
  localparam int CNT_W = $clog2(WIDTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   grp_size,
  input  logic [3*WIDTH-1:0] grp_cls,
  input  logic [WIDTH-1:0]   grp_sq,
  input  logic [FREE_W-1:0]  iq_free,
  output logic [WIDTH-1:0]   iq_o,
  output logic [WIDTH-1:0]   ld_o,
  output logic [WIDTH-1:0]   st_o,
  output logic [WIDTH-1:0]   ns_o,
  output logic [WIDTH-1:0]   nop_o,
  output logic [WIDTH-1:0]   drop_o,
  output logic [CNT_W-1:0]   cnt_drop_o,
  output logic [CNT_W-1:0]   cnt_ld_o,
  output logic [CNT_W-1:0]   cnt_st_o,
  output logic [CNT_W-1:0]   cnt_disp_o,
  output logic               block_o,
  output logic               stall_o
);
  logic [WIDTH-1:0] iq_c, ld_c, st_c, ns_c, nop_c, drop_c;
  logic             full_c;
  logic [CNT_W-1:0] n_drop, n_ld, n_st, n_disp;

  dsu_chain #(.WIDTH(WIDTH), .FREE_W(FREE_W)) u_chain (
    .grp_size(grp_size), .grp_cls(grp_cls), .grp_sq(grp_sq), .iq_free(iq_free),
    .iq_c(iq_c), .ld_c(ld_c), .st_c(st_c), .ns_c(ns_c), .nop_c(nop_c),
    .drop_c(drop_c), .full_c(full_c)
  );

  dsu_tally #(.WIDTH(WIDTH)) u_t_drop (.bits(drop_c), .cnt(n_drop));
  dsu_tally #(.WIDTH(WIDTH)) u_t_ld   (.bits(ld_c),   .cnt(n_ld));
  dsu_tally #(.WIDTH(WIDTH)) u_t_st   (.bits(st_c),   .cnt(n_st));
  dsu_tally #(.WIDTH(WIDTH)) u_t_disp (.bits(iq_c),   .cnt(n_disp));

  // R9: one register stage, cleared by reset
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iq_o <= '0; ld_o <= '0; st_o <= '0; ns_o <= '0; nop_o <= '0; drop_o <= '0;
      cnt_drop_o <= '0; cnt_ld_o <= '0; cnt_st_o <= '0; cnt_disp_o <= '0;
      block_o <= 1'b0; stall_o <= 1'b0;
    end else begin
      iq_o <= iq_c; ld_o <= ld_c; st_o <= st_c; ns_o <= ns_c;
      nop_o <= nop_c; drop_o <= drop_c;
      cnt_drop_o <= n_drop; cnt_ld_o <= n_ld; cnt_st_o <= n_st; cnt_disp_o <= n_disp;
      block_o <= full_c; stall_o <= full_c;
    end
  end

  logic [WIDTH-1:0] touched;
  assign touched = iq_o | ns_o | nop_o | drop_o;

  // R4
  ld_st_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_o & st_o) == '0);

  // R4
  mem_has_iq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ld_o | st_o) & ~iq_o) == '0);

  // R5
  path_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((iq_o & ns_o) | (iq_o & nop_o) | (ns_o & nop_o) |
     (drop_o & (iq_o | ns_o | nop_o))) == '0);

  // R1
  contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (touched[WIDTH-1:1] & ~touched[WIDTH-2:0]) == '0);

  // R1
  within_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n && $past(rst_n) |-> $countones(touched) <= int'($past(grp_size)));

  // R3
  stall_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o && $past(rst_n) |-> $countones(iq_o | ns_o | nop_o) == int'($past(iq_free)));
endmodule

// File: tb/dsu_top_tb_top.sv
module dsu_top_tb_top;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0]  grp_size = '0;
  logic [11:0] grp_cls = '0;
  logic [3:0]  grp_sq = '0;
  logic [3:0]  iq_free = '0;
  logic [3:0]  iq_o, ld_o, st_o, ns_o, nop_o, drop_o;
  logic [2:0]  cnt_drop_o, cnt_ld_o, cnt_st_o, cnt_disp_o;
  logic        block_o, stall_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dsu_top dut_i (
    .clk(clk), .rst_n(rst_n), .grp_size(grp_size), .grp_cls(grp_cls),
    .grp_sq(grp_sq), .iq_free(iq_free), .iq_o(iq_o), .ld_o(ld_o), .st_o(st_o),
    .ns_o(ns_o), .nop_o(nop_o), .drop_o(drop_o), .cnt_drop_o(cnt_drop_o),
    .cnt_ld_o(cnt_ld_o), .cnt_st_o(cnt_st_o), .cnt_disp_o(cnt_disp_o),
    .block_o(block_o), .stall_o(stall_o)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int ones(input logic [3:0] v);
    return int'(v[0]) + int'(v[1]) + int'(v[2]) + int'(v[3]);
  endfunction

  // Expected strobes from the requirements.
  task automatic model(input logic [2:0] sz, input logic [11:0] cls,
                       input logic [3:0] sq, input logic [3:0] fr,
                       output logic [3:0] e_iq, output logic [3:0] e_ld,
                       output logic [3:0] e_st, output logic [3:0] e_ns,
                       output logic [3:0] e_nop, output logic [3:0] e_drop,
                       output logic e_full);
    int left;
    bit halt;
    logic [2:0] c;
    left = int'(fr);
    halt = 1'b0;
    e_iq = '0; e_ld = '0; e_st = '0; e_ns = '0; e_nop = '0; e_drop = '0;
    for (int k = 0; k < W; k++) begin
      if (k >= int'(sz) || halt) continue;
      c = cls[3*k +: 3];
      if (sq[k]) begin e_drop[k] = 1'b1; continue; end
      if (left == 0) begin halt = 1'b1; continue; end
      left = left - 1;
      if (c == 3'd1) begin e_ld[k] = 1'b1; e_iq[k] = 1'b1; end
      else if (c == 3'd2) begin e_st[k] = 1'b1; e_iq[k] = 1'b1; end
      else if (c == 3'd3) e_ns[k] = 1'b1;
      else if (c == 3'd4) e_nop[k] = 1'b1;
      else e_iq[k] = 1'b1;
    end
    e_full = halt;
  endtask

  task automatic run(input logic [2:0] sz, input logic [11:0] cls,
                     input logic [3:0] sq, input logic [3:0] fr);
    logic [3:0] e_iq, e_ld, e_st, e_ns, e_nop, e_drop;
    logic e_full;
    grp_size = sz; grp_cls = cls; grp_sq = sq; iq_free = fr;
    model(sz, cls, sq, fr, e_iq, e_ld, e_st, e_ns, e_nop, e_drop, e_full);
    @(negedge clk);
    chk("R7 iq strobes", int'(iq_o), int'(e_iq));
    chk("R4 load strobes", int'(ld_o), int'(e_ld));
    chk("R4 store strobes", int'(st_o), int'(e_st));
    chk("R5 nonspec strobes", int'(ns_o), int'(e_ns));
    chk("R6 nop strobes", int'(nop_o), int'(e_nop));
    chk("R2 drop strobes", int'(drop_o), int'(e_drop));
    chk("R2 drop count", int'(cnt_drop_o), ones(e_drop));
    chk("R4 load count", int'(cnt_ld_o), ones(e_ld));
    chk("R4 store count", int'(cnt_st_o), ones(e_st));
    chk("R7 dispatch count", int'(cnt_disp_o), ones(e_iq));
    chk("R3 block", int'(block_o), int'(e_full));
    chk("R3 stall", int'(stall_o), int'(e_full));
  endtask

  initial begin
    void'($urandom(32'h5eed_0041));
    grp_size = 3'd4; grp_cls = 12'h249; grp_sq = 4'h0; iq_free = 4'd8;
    repeat (3) @(negedge clk);
    // R9: outputs stay clear during reset despite a full valid group
    chk("R9 reset strobes", int'({iq_o, ld_o, st_o, ns_o, nop_o, drop_o}), 0);
    chk("R9 reset flags", int'({block_o, stall_o, cnt_disp_o}), 0);
    rst_n = 1'b1;

    // R6 R3 R8: four no-ops, two free entries -> stop at slot 2
    run(3'd4, {3'd4, 3'd4, 3'd4, 3'd4}, 4'b0000, 4'd2);
    // R2 R3: squashed slot 0 dropped even with an empty queue, slot 1 stops
    run(3'd4, {3'd0, 3'd0, 3'd0, 3'd1}, 4'b0001, 4'd0);
    // R7: codes 5,6,7,0 are ordinary
    run(3'd4, {3'd0, 3'd7, 3'd6, 3'd5}, 4'b0000, 4'd8);
    // R1: empty group touches nothing
    run(3'd0, {3'd1, 3'd2, 3'd3, 3'd4}, 4'b0000, 4'd8);
    // R1: group of two, later slots ignored
    run(3'd2, {3'd1, 3'd1, 3'd2, 3'd1}, 4'b0000, 4'd8);
    // R4 R5 R6 R8: mix with exactly enough entries
    run(3'd4, {3'd4, 3'd3, 3'd2, 3'd1}, 4'b0000, 4'd4);
    // R2 R8: squashed slots consume nothing, last slot still fits
    run(3'd4, {3'd0, 3'd0, 3'd0, 3'd0}, 4'b0110, 4'd2);

    for (int n = 0; n < 3000; n++) begin
      run(3'($urandom_range(0, 4)), 12'($urandom), 4'($urandom),
          4'($urandom_range(0, 6)));
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R9 watchdog: got %0d expected %0d", 0, 1);
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule